// File: doc/BRIEF.md
# Switched-Capacitor Bandpass Tuning Clock Generator

This block sets up an external switched-capacitor bandpass filter from one small selection index. A table built at elaboration time holds one entry for each supported center frequency. Each entry carries three values: a 5-bit frequency code, a 7-bit quality code and a half-period count. The two codes drive static pins of the filter. The half-period count sets a square-wave divider that produces the filter's sampling clock from the system clock. Both second-order sections of the external filter take the same codes and the same clock, and are cascaded to give a fourth-order response.

The filter ties its center frequency to its clock by f_clk / f0 = pi * (N + 13), where N is the 5-bit frequency code. For each center frequency the table picks the largest N whose rounded half-period count is still at least MIN_HALF system cycles, because a higher clock-to-center ratio gives smoother filtering. The quality factor follows Q = 64 / (128 - M), where M is the 7-bit code. Each entry aims at a constant bandwidth BW_HZ, so M = 128 - round(64 * BW_HZ / f0).

When the selection changes, the new entry takes effect only at the next toggle of the square wave, so no level is cut short. An out-of-range index leaves the running settings unchanged and raises an error flag.

Top module: `scf_tune_top`

## Requirements
- R1: After reset, the codes show entry 0, the square-wave output is low and the error flag is low.
- R2: For the applied entry i, every level of the square wave lasts exactly HALF(i) system cycles. Here HALF(n, f) = round(SYS_HZ / (2 * pi * (n + 13) * f)), and entry i has f0(i) = F_BASE_HZ + i * F_STEP_HZ.
- R3: The frequency code of entry i is the largest n in 0..31 with HALF(n, f0(i)) >= MIN_HALF, or 0 if no n qualifies.
- R4: The quality code of entry i is 128 - round(64 * BW_HZ / f0(i)), clamped to 0..127.
- R5: A selection change does not alter the square-wave level that is running when the change arrives. That level keeps its old length, and the new length starts with the next level.
- R6: The code outputs change on the same clock edge as the square-wave toggle that starts the first level at the new length, and at no other edge.
- R7: An index of NUM_ENT or more raises the error flag one cycle later. While it is present, the codes and the half-period in use stay as they were.
- R8: The error flag drops one cycle after the index is back in range, and the new valid entry is then applied at the next toggle.
- R9: The square wave has a 50% duty cycle: the high and low levels of a given entry have equal lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (SYS_HZ) |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | IDX_W | Center frequency selection index |
| fcode_o | output | 5 | Frequency code to the filter's N pins |
| qcode_o | output | 7 | Quality code to the filter's Q pins |
| fclk_o | output | 1 | Square-wave sampling clock to the filter |
| err_o | output | 1 | High while the selection index is out of range |

## Verification
The assertions check the following on every cycle:
- The square wave toggles only when its down-counter has expired.
- The codes hold steady between toggles.
- An out-of-range index raises the flag and freezes the codes through a toggle.

Only the bench scenarios can show the rest:
- The level lengths match the table's formulas for each entry, and high and low levels are equal.
- A retune leaves the level already running at its old length.
- The codes change exactly at the toggle that starts the first level at the new length.

// File: rtl/scf_tune_pkg.sv
package scf_tune_pkg;

  localparam int unsigned FC_W   = 5;
  localparam int unsigned QC_W   = 7;
  localparam int unsigned HALF_W = 16;

  // pi scaled by 1e6
  localparam longint PI_U = 64'd3141593;

  typedef struct packed {
    logic [FC_W-1:0]   fc;
    logic [QC_W-1:0]   qc;
    logic [HALF_W-1:0] half;
  } tune_t;

  function automatic longint center_hz(input longint base, input longint step, input int idx);
    return base + step * longint'(idx);
  endfunction

  // round(sys / (2*pi*(n+13)*f))
  function automatic longint half_count(input longint sys, input int n, input longint f);
    longint den;
    den = 64'd2 * PI_U * longint'(n + 13) * f;
    return (sys * 64'd1000000 + den / 2) / den;
  endfunction

  // Largest 5-bit code whose half-period stays at or above min_half
  function automatic int pick_fcode(input longint sys, input longint f, input int min_half);
    int best;
    best = 0;
    for (int n = 0; n < 32; n++) begin
      if (half_count(sys, n, f) >= longint'(min_half)) best = n;
    end
    return best;
  endfunction

  // Constant bandwidth: code = 128 - round(64*bw/f)
  function automatic int pick_qcode(input longint f, input longint bw);
    longint r;
    longint c;
    r = (64 * bw + f / 2) / f;
    c = 128 - r;
    if (c < 0)   c = 0;
    if (c > 127) c = 127;
    return int'(c);
  endfunction

endpackage

// File: rtl/scf_tune_table.sv
module scf_tune_table
  import scf_tune_pkg::*;
#(
  parameter longint SYS_HZ    = 50_000_000,
  parameter int     NUM_ENT   = 8,
  parameter int     IDX_W     = 4,
  parameter longint F_BASE_HZ = 20_000,
  parameter longint F_STEP_HZ = 2_500,
  parameter longint BW_HZ     = 2_000,
  parameter int     MIN_HALF  = 8
) (
  input  logic [IDX_W-1:0] sel_i,
  output tune_t            ent_o,
  output tune_t            ent0_o,
  output logic             bad_o
);

  tune_t ent [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    localparam longint FHZ  = center_hz(F_BASE_HZ, F_STEP_HZ, i);
    localparam int     FC   = pick_fcode(SYS_HZ, FHZ, MIN_HALF);
    localparam int     QC   = pick_qcode(FHZ, BW_HZ);
    localparam longint HC   = half_count(SYS_HZ, FC, FHZ);
    assign ent[i].fc   = FC_W'(FC);
    assign ent[i].qc   = QC_W'(QC);
    assign ent[i].half = HALF_W'(HC);
  end

  assign ent0_o = ent[0];
  assign bad_o  = (32'(sel_i) >= 32'(NUM_ENT));

  always_comb begin
    ent_o = ent[0];
    for (int k = 0; k < NUM_ENT; k++) begin
      if (32'(sel_i) == 32'(k)) ent_o = ent[k];
    end
  end

endmodule

// File: rtl/scf_sqw_gen.sv
module scf_sqw_gen
  import scf_tune_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] rst_half_i,
  input  logic [HALF_W-1:0] next_half_i,
  output logic              sq_o,
  output logic              edge_o
);

  logic [HALF_W-1:0] cnt_q;

  assign edge_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= rst_half_i - 1'b1;
      sq_o  <= 1'b0;
    end else if (edge_o) begin
      cnt_q <= next_half_i - 1'b1;
      sq_o  <= ~sq_o;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2: level changes only when the count has run out
  p_toggle_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(sq_o));

  // R9: every expiry flips the level
  p_flip_on_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (sq_o != $past(sq_o)));

endmodule

// File: rtl/scf_tune_top.sv
module scf_tune_top
  import scf_tune_pkg::*;
#(
  parameter longint SYS_HZ    = 50_000_000,
  parameter int     NUM_ENT   = 8,
  parameter int     IDX_W     = 4,
  parameter longint F_BASE_HZ = 20_000,
  parameter longint F_STEP_HZ = 2_500,
  parameter longint BW_HZ     = 2_000,
  parameter int     MIN_HALF  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sel_i,
  output logic [4:0]       fcode_o,
  output logic [6:0]       qcode_o,
  output logic             fclk_o,
  output logic             err_o
);

  tune_t             lut_ent;
  tune_t             ent0;
  logic              sel_bad;
  logic              tog_edge;
  logic [HALF_W-1:0] act_half_q;
  logic [HALF_W-1:0] next_half;
  logic              apply_new;

  scf_tune_table #(
    .SYS_HZ(SYS_HZ), .NUM_ENT(NUM_ENT), .IDX_W(IDX_W),
    .F_BASE_HZ(F_BASE_HZ), .F_STEP_HZ(F_STEP_HZ),
    .BW_HZ(BW_HZ), .MIN_HALF(MIN_HALF)
  ) u_table (
    .sel_i (sel_i),
    .ent_o (lut_ent),
    .ent0_o(ent0),
    .bad_o (sel_bad)
  );

  assign apply_new = tog_edge && !sel_bad;
  assign next_half = sel_bad ? act_half_q : lut_ent.half;

  scf_sqw_gen u_sqw (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_half_i (ent0.half),
    .next_half_i(next_half),
    .sq_o       (fclk_o),
    .edge_o     (tog_edge)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcode_o    <= ent0.fc;
      qcode_o    <= ent0.qc;
      act_half_q <= ent0.half;
      err_o      <= 1'b0;
    end else begin
      err_o <= sel_bad;
      if (apply_new) begin
        fcode_o    <= lut_ent.fc;
        qcode_o    <= lut_ent.qc;
        act_half_q <= lut_ent.half;
      end
    end
  end

  // R6: codes move only at a toggle edge
  p_codes_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tog_edge |=> ($stable(fcode_o) && $stable(qcode_o)));

  // R7: out-of-range index raises the flag a cycle later
  p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_bad |=> err_o);

  // R7: a toggle under a bad index keeps the codes
  p_keep_on_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_edge && sel_bad) |=> ($stable(fcode_o) && $stable(qcode_o)));

  // R8: flag clears once the index is valid
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_bad |=> !err_o);

endmodule

// File: tb/tb_scf_tune_top.sv
module tb_scf_tune_top;

  localparam int NUM_ENT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel = 4'd0;
  logic [4:0] fcode;
  logic [6:0] qcode;
  logic       fclk;
  logic       err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scf_tune_top dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel),
    .fcode_o(fcode), .qcode_o(qcode), .fclk_o(fclk), .err_o(err)
  );

  // Independent model of the table
  function automatic real f0(input int i);
    return 20000.0 + 2500.0 * i;
  endfunction
  function automatic int hlen(input int n, input real f);
    real x;
    x = 50.0e6 / (2.0 * 3.14159265 * (n + 13) * f);
    return $rtoi(x + 0.5);
  endfunction
  function automatic int exp_fc(input int i);
    int b;
    b = 0;
    for (int n = 0; n < 32; n++) if (hlen(n, f0(i)) >= 8) b = n;
    return b;
  endfunction
  function automatic int exp_qc(input int i);
    return 128 - $rtoi(64.0 * 2000.0 / f0(i) + 0.5);
  endfunction
  function automatic int exp_half(input int i);
    return hlen(exp_fc(i), f0(i));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_toggle();
    logic lv;
    @(negedge clk);
    lv = fclk;
    while (fclk == lv) @(negedge clk);
  endtask

  // Call at the negedge where a new level is first seen; ends at the next one
  task automatic measure(output int len);
    logic lv;
    lv = fclk;
    len = 1;
    @(negedge clk);
    while (fclk == lv) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(fcode == 5'(exp_fc(0)), "R1 fcode", fcode, exp_fc(0));
    chk(qcode == 7'(exp_qc(0)), "R1 qcode", qcode, exp_qc(0));
    chk(fclk == 1'b0, "R1 fclk", fclk, 0);
    chk(err == 1'b0, "R1 err", err, 0);
  endtask

  task automatic t_entry(input int i);
    int a;
    int b;
    sel = 4'(i);
    wait_toggle();
    wait_toggle();
    measure(a);
    measure(b);
    chk(a == exp_half(i), "R2 level length", a, exp_half(i));
    chk(a == b, "R9 duty", b, a);
    chk(fcode == 5'(exp_fc(i)), "R3 fcode", fcode, exp_fc(i));
    chk(qcode == 7'(exp_qc(i)), "R4 qcode", qcode, exp_qc(i));
  endtask

  task automatic t_retune(input int from, input int to);
    int len;
    logic lv;
    bit codes_ok;
    sel = 4'(from);
    wait_toggle();
    wait_toggle();
    lv = fclk;
    len = 1;
    @(negedge clk); len++;
    @(negedge clk); len++;
    sel = 4'(to);
    codes_ok = 1'b1;
    @(negedge clk);
    while (fclk == lv) begin
      if (fcode != 5'(exp_fc(from)) || qcode != 7'(exp_qc(from))) codes_ok = 1'b0;
      len++;
      @(negedge clk);
    end
    chk(len == exp_half(from), "R5 running level kept", len, exp_half(from));
    chk(codes_ok, "R6 codes before toggle", fcode, exp_fc(from));
    chk(fcode == 5'(exp_fc(to)) && qcode == 7'(exp_qc(to)), "R6 codes at toggle", fcode, exp_fc(to));
    measure(len);
    chk(len == exp_half(to), "R5 new level length", len, exp_half(to));
  endtask

  task automatic t_bad(input int keep, input int badv, input int after);
    int len;
    sel = 4'(keep);
    wait_toggle();
    wait_toggle();
    sel = 4'(badv);
    @(negedge clk);
    chk(err == 1'b1, "R7 err raised", err, 1);
    wait_toggle();
    measure(len);
    chk(len == exp_half(keep), "R7 half kept", len, exp_half(keep));
    chk(fcode == 5'(exp_fc(keep)) && qcode == 7'(exp_qc(keep)), "R7 codes kept", fcode, exp_fc(keep));
    sel = 4'(after);
    @(negedge clk);
    chk(err == 1'b0, "R8 err cleared", err, 0);
    wait_toggle();
    measure(len);
    chk(len == exp_half(after), "R8 valid entry applied", len, exp_half(after));
    chk(fcode == 5'(exp_fc(after)), "R8 fcode applied", fcode, exp_fc(after));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    for (int i = 0; i < NUM_ENT; i++) t_entry(i);
    t_retune(1, 6);
    t_retune(7, 0);
    t_bad(3, 12, 5);
    t_bad(5, 8, 2);
    finish_run();
  end

endmodule